// File: doc/BRIEF.md
# External Interrupt and DMA Request Controller

This block watches sixteen external request pins and turns selected edges on them into per-pin status flags. Each pin can be told to react to a rising edge, a falling edge or both. Once a flag is set, it is routed to one of two places, chosen per pin. It can raise that pin's own DMA request line, which a matching DMA done pulse later clears. Or it can feed one combined interrupt line. A pin can also have request generation switched off; its flag then still records the edge, so software can poll it.

If a selected edge arrives while the pin's flag is still set, the block records an overrun for that pin. Overrun bits have their own enable mask. All enabled overruns are ORed into a single overrun interrupt.

Software reaches the block through a plain 32-bit register bus with one write strobe and a combinational read port. The pins pass through a two-flop synchroniser before edge detection. No glitch filter is applied; the filter control slot reads as zero.

Top module: `ext_req_ctrl`

## Requirements
- R1: After reset, every register reads zero and the DMA request, interrupt and overrun interrupt outputs are low.
- R2: With the rising-edge enable bit of pin n set, a 0-to-1 change on pin n sets bit n of the status register (offset 0x14). The bit reads as 1 at the third rising clock edge after the pin change.
- R3: With the falling-edge enable bit (offset 0x2C) set, a 1-to-0 change sets the status bit. With both the falling-edge bit and the rising-edge bit (offset 0x28) set, either change sets it.
- R4: A pin change whose direction is not enabled for that pin leaves the status and overrun status registers unchanged.
- R5: DMA request output n is high exactly when status bit n, request-enable bit n (offset 0x18) and select bit n (offset 0x1C) are all 1.
- R6: The interrupt output is high exactly when some pin has its status bit and request-enable bit set and its select bit clear.
- R7: A one-cycle pulse on DMA done input n clears status bit n at the next clock edge.
- R8: The status register is write-1-to-clear: a 1 clears the bit and a 0 leaves it. If a selected edge lands in the same cycle as a clear of that bit, the bit stays set.
- R9: A selected edge on a pin whose status bit is already set sets that pin's bit in the overrun status register (offset 0x20). This register is write-1-to-clear.
- R10: The overrun interrupt output is high exactly when some bit is set in both the overrun status register and the overrun enable register (offset 0x24).
- R11: Bits 31 to 16 of every register read as zero. The filter control slot (offset 0x30) and unused offsets read as zero and ignore writes.
- R12: The request-enable, select, overrun-enable and both edge-enable registers read back the low 16 bits last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | External request pins, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from address |
| dma_req_o | output | 16 | Per-pin DMA request |
| dma_done_i | input | 16 | Per-pin DMA done pulse |
| irq_o | output | 1 | Combined interrupt request |
| ovr_irq_o | output | 1 | Combined overrun interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- a detected edge always leaves its flag set on the next cycle;
- a flag never rises without an edge;
- a done pulse without a competing edge always clears its flag;
- an edge on a set flag always records an overrun;
- a DMA request never appears without its enable and select bits.

Other behaviour can only be shown by the bench scenarios:
- the exact three-cycle latency from a pin change;
- which edge directions each enable combination accepts;
- write-1-to-clear with zero writes ignored;
- the edge-beats-clear collision;
- per-pin routing between DMA and the combined interrupt;
- register readback with zero upper bits.

// File: rtl/ext_req_pkg.sv
`timescale 1ns/1ps
package ext_req_pkg;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_ENABLE = 8'h18;
    localparam logic [7:0] OFS_SELECT = 8'h1C;
    localparam logic [7:0] OFS_OVR    = 8'h20;
    localparam logic [7:0] OFS_OVR_EN = 8'h24;
    localparam logic [7:0] OFS_RISE   = 8'h28;
    localparam logic [7:0] OFS_FALL   = 8'h2C;
    localparam logic [7:0] OFS_FILTER = 8'h30;
endpackage

// File: rtl/ext_req_sync.sv
`timescale 1ns/1ps
module ext_req_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] ev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pin_i;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
        ev_o = (rise_en_i &  st_q.stable & ~st_q.prev)
             | (fall_en_i & ~st_q.stable &  st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ext_req_cfg.sv
`timescale 1ns/1ps
module ext_req_cfg
    import ext_req_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [W-1:0]  en_o,
    output logic [W-1:0]  sel_o,
    output logic [W-1:0]  oen_o,
    output logic [W-1:0]  rise_o,
    output logic [W-1:0]  fall_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] sel;
        logic [W-1:0] oen;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [W-1:0] wlow;

    always_comb begin
        cfg_d = cfg_q;
        wlow  = wdata_i[W-1:0];
        if (wr_i) begin
            case (addr_i)
                AW'(OFS_ENABLE): cfg_d.en   = wlow;
                AW'(OFS_SELECT): cfg_d.sel  = wlow;
                AW'(OFS_OVR_EN): cfg_d.oen  = wlow;
                AW'(OFS_RISE):   cfg_d.rise = wlow;
                AW'(OFS_FALL):   cfg_d.fall = wlow;
                default:         ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o   = cfg_q.en;
    assign sel_o  = cfg_q.sel;
    assign oen_o  = cfg_q.oen;
    assign rise_o = cfg_q.rise;
    assign fall_o = cfg_q.fall;
endmodule

// File: rtl/ext_req_flags.sv
`timescale 1ns/1ps
module ext_req_flags #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic [W-1:0] clr_flag_i,
    input  logic [W-1:0] clr_ovr_i,
    input  logic [W-1:0] done_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] ovr_o
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] ovr;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d      = fl_q;
        // a new edge outranks any clear in the same cycle
        fl_d.flag = (fl_q.flag & ~clr_flag_i & ~done_i) | ev_i;
        fl_d.ovr  = (fl_q.ovr & ~clr_ovr_i) | (ev_i & fl_q.flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag_o = fl_q.flag;
    assign ovr_o  = fl_q.ovr;
endmodule

// File: rtl/ext_req_ctrl.sv
`timescale 1ns/1ps
module ext_req_ctrl
    import ext_req_pkg::*;
#(
    parameter int unsigned NPIN = 16,
    parameter int unsigned AW   = 8,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic [NPIN-1:0] dma_req_o,
    input  logic [NPIN-1:0] dma_done_i,
    output logic            irq_o,
    output logic            ovr_irq_o
);
    logic [NPIN-1:0] ev_w, flag_w, ovr_w;
    logic [NPIN-1:0] en_w, sel_w, oen_w, rise_w, fall_w;
    logic [NPIN-1:0] clr_flag_w, clr_ovr_w;

    ext_req_sync #(.W(NPIN)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .rise_en_i (rise_w),
        .fall_en_i (fall_w),
        .ev_o      (ev_w)
    );

    ext_req_cfg #(.W(NPIN), .AW(AW), .DW(DW)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .en_o    (en_w),
        .sel_o   (sel_w),
        .oen_o   (oen_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    always_comb begin
        clr_flag_w = '0;
        clr_ovr_w  = '0;
        if (bus_wr_i && bus_addr_i == AW'(OFS_STATUS)) clr_flag_w = bus_wdata_i[NPIN-1:0];
        if (bus_wr_i && bus_addr_i == AW'(OFS_OVR))    clr_ovr_w  = bus_wdata_i[NPIN-1:0];
    end

    ext_req_flags #(.W(NPIN)) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_w),
        .clr_flag_i (clr_flag_w),
        .clr_ovr_i  (clr_ovr_w),
        .done_i     (dma_done_i),
        .flag_o     (flag_w),
        .ovr_o      (ovr_w)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            AW'(OFS_STATUS): bus_rdata_o = DW'(flag_w);
            AW'(OFS_ENABLE): bus_rdata_o = DW'(en_w);
            AW'(OFS_SELECT): bus_rdata_o = DW'(sel_w);
            AW'(OFS_OVR):    bus_rdata_o = DW'(ovr_w);
            AW'(OFS_OVR_EN): bus_rdata_o = DW'(oen_w);
            AW'(OFS_RISE):   bus_rdata_o = DW'(rise_w);
            AW'(OFS_FALL):   bus_rdata_o = DW'(fall_w);
            default:         bus_rdata_o = '0;
        endcase
    end

    assign dma_req_o = flag_w & en_w & sel_w;
    assign irq_o     = |(flag_w & en_w & ~sel_w);
    assign ovr_irq_o = |(ovr_w & oen_w);
endmodule

// File: rtl/ext_req_ctrl_chk.sv
`timescale 1ns/1ps
module ext_req_ctrl_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] ev,
    input logic [W-1:0] flag,
    input logic [W-1:0] ovr,
    input logic [W-1:0] en,
    input logic [W-1:0] sel,
    input logic [W-1:0] done,
    input logic [W-1:0] dma_req,
    input logic         irq,
    input logic         ovr_irq
);
    // R2
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & $past(ev)) == $past(ev)));

    // R4
    flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(ev)) == '0));

    // R7
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & $past(done & ~ev)) == '0));

    // R9
    ovr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovr & $past(ev & flag)) == $past(ev & flag)));

    // R5
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req & ~(en & sel & flag)) == '0);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag != '0));

    // R10
    ovr_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq |-> (ovr != '0));
endmodule

bind ext_req_ctrl ext_req_ctrl_chk #(.W(NPIN)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_w),
    .flag    (flag_w),
    .ovr     (ovr_w),
    .en      (en_w),
    .sel     (sel_w),
    .done    (dma_done_i),
    .dma_req (dma_req_o),
    .irq     (irq_o),
    .ovr_irq (ovr_irq_o)
);

// File: tb/test_ext_req_ctrl.sv
`timescale 1ns/1ps
module test_ext_req_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] dma_req;
    logic [15:0] dma_done = '0;
    logic        irq, ovr_irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    ext_req_ctrl i_ext_req_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .dma_req_o(dma_req), .dma_done_i(dma_done), .irq_o(irq), .ovr_irq_o(ovr_irq)
    );

    localparam logic [7:0] A_ST = 8'h14, A_EN = 8'h18, A_SEL = 8'h1C, A_OVR = 8'h20,
                           A_OEN = 8'h24, A_RISE = 8'h28, A_FALL = 8'h2C, A_FLT = 8'h30;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    // drive pins, then wait until a resulting flag is visible (3 posedges)
    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pins = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(2.5 * 2 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] en_p, sel_p, expf;
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 64; a += 4) rd_check("R1 reset read", 8'(a), 32'h0);
        check("R1 dma_req", {16'h0, dma_req}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 ovr_irq", {31'h0, ovr_irq}, 32'h0);

        // R12 / R11: readback, upper bits zero
        wr(A_EN, 32'hFFFF_A5C3);   rd_check("R12 enable", A_EN, 32'h0000_A5C3);
        wr(A_SEL, 32'h1234_5A3C);  rd_check("R12 select", A_SEL, 32'h0000_5A3C);
        wr(A_OEN, 32'hDEAD_0F0F);  rd_check("R12 ovr enable", A_OEN, 32'h0000_0F0F);
        wr(A_RISE, 32'hBEEF_C001); rd_check("R12 rise", A_RISE, 32'h0000_C001);
        wr(A_FALL, 32'hCAFE_7FFE); rd_check("R12 fall", A_FALL, 32'h0000_7FFE);
        wr(A_FLT, 32'hFFFF_FFFF);  rd_check("R11 filter", A_FLT, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);  rd_check("R11 unused", 8'h40, 32'h0);
        wr(A_EN, 0); wr(A_SEL, 0); wr(A_OEN, 0); wr(A_FALL, 0);

        // R2 rising sweep, R8 zero write, R4 falling ignored
        wr(A_RISE, 32'hFFFF);
        for (int i = 0; i < 16; i++) begin
            set_pins(16'(1 << i));
            rd_check("R2 rise sets flag", A_ST, 32'(1 << i));
            wr(A_ST, 32'h0);
            rd_check("R8 zero write keeps", A_ST, 32'(1 << i));
            wr(A_ST, 32'(1 << i));
            rd_check("R8 one write clears", A_ST, 32'h0);
            set_pins(16'h0);
            rd_check("R4 fall ignored", A_ST, 32'h0);
        end

        // R3 falling sweep, then both edges
        wr(A_RISE, 0); wr(A_FALL, 32'hFFFF);
        for (int i = 0; i < 16; i++) begin
            set_pins(16'(1 << i));
            rd_check("R4 rise ignored", A_ST, 32'h0);
            set_pins(16'h0);
            rd_check("R3 fall sets flag", A_ST, 32'(1 << i));
            wr(A_ST, 32'(1 << i));
        end
        wr(A_RISE, 32'hFFFF);
        for (int i = 0; i < 16; i++) begin
            set_pins(16'(1 << i));
            rd_check("R3 both rise", A_ST, 32'(1 << i));
            wr(A_ST, 32'hFFFF);
            set_pins(16'h0);
            rd_check("R3 both fall", A_ST, 32'(1 << i));
            wr(A_ST, 32'hFFFF);
        end

        // R4: nothing enabled, no flag or overrun
        wr(A_RISE, 0); wr(A_FALL, 0);
        set_pins(16'hFFFF);
        set_pins(16'h0);
        rd_check("R4 disabled status", A_ST, 32'h0);
        rd_check("R4 disabled ovr", A_OVR, 32'h0);

        // R5 / R6 routing over several enable/select patterns
        wr(A_RISE, 32'hFFFF);
        set_pins(16'hFFFF);
        rd_check("R2 all pins", A_ST, 32'hFFFF);
        for (int k = 0; k < 8; k++) begin
            en_p  = 16'(16'hF0F0 ^ (k * 16'h1357));
            sel_p = 16'(16'h00FF + (k * 16'h2468));
            if (k == 6) en_p = 16'h0;
            if (k == 7) begin en_p = 16'hFFFF; sel_p = 16'hFFFF; end
            wr(A_EN, 32'(en_p)); wr(A_SEL, 32'(sel_p));
            check("R5 dma routing", {16'h0, dma_req}, 32'(en_p & sel_p));
            check("R6 irq routing", {31'h0, irq}, {31'h0, |(en_p & ~sel_p)});
        end

        // R7: done pulses clear one flag each
        expf = 16'hFFFF;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); dma_done = 16'(1 << i);
            @(negedge clk); dma_done = '0;
            expf = expf & ~16'(1 << i);
            rd_check("R7 done clears", A_ST, 32'(expf));
            check("R7 dma request drops", {16'h0, dma_req}, 32'(expf));
        end
        wr(A_EN, 0); wr(A_SEL, 0);

        // R9 / R10: overrun per pin (pins start high)
        wr(A_FALL, 32'hFFFF); wr(A_OEN, 32'h5555);
        for (int i = 0; i < 16; i++) begin
            set_pins(~16'(1 << i));
            rd_check("R9 first edge no ovr", A_OVR, 32'h0);
            set_pins(16'hFFFF);
            rd_check("R9 ovr set", A_OVR, 32'(1 << i));
            check("R10 ovr irq", {31'h0, ovr_irq}, {31'h0, (i % 2) == 0});
            wr(A_OVR, 32'(1 << i));
            rd_check("R9 ovr w1c", A_OVR, 32'h0);
            check("R10 ovr irq cleared", {31'h0, ovr_irq}, 32'h0);
            wr(A_ST, 32'hFFFF);
        end

        // R8: edge in same cycle as clear keeps the flag, R9 records overrun
        set_pins(16'hFFF7);
        rd_check("R3 pin3 fall", A_ST, 32'h8);
        @(negedge clk); pins = 16'hFFFF;
        repeat (2) @(posedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h8;
        @(negedge clk); bus_wr = 1'b0;
        rd_check("R8 edge beats clear", A_ST, 32'h8);
        rd_check("R9 overrun on collision", A_OVR, 32'h8);
        wr(A_ST, 32'h8);
        rd_check("R8 clear after collision", A_ST, 32'h0);

        rd(A_OEN, d);
        check("R12 ovr enable kept", d, 32'h5555);
        finish_run();
    end
endmodule